// File: doc/BRIEF.md
# Configuration Port to ECAM Bridge

This block sits behind a small 8-byte register window and converts the classic two-step configuration access into single memory-mapped configuration requests. Software first writes a 32-bit selector word at window offset 0. That word carries an enable flag, a bus, a device, a function and a register offset. Software then reads or writes offsets 4 to 7. Each such access becomes one downstream request. Its address is computed from the selector word, and the low two offset bits pick the byte lane.

The upstream master holds its request until the bridge pulses a done strobe. Accesses that need no downstream transfer are answered locally. These are selector accesses, unused offsets, and data accesses while the enable flag is clear. Forwarded accesses wait for the downstream valid/ready handshake, and only one downstream request is open at any time. Read data coming back is cut to the requested width. Write data and size are passed on unchanged.

Top module: `cfg_port_bridge`

## Requirements
- R1: After reset the selector word is zero. A 4-byte read at offset 0 returns 0, and a data-port read returns 0 without raising `ecam_valid`.
- R2: A write at offset 0 loads the selector word only when `up_size` is 4. Writes of size 1 or 2 at offset 0 leave it unchanged.
- R3: A read at offset 0 returns the selector word when `up_size` is 4 and returns 0 for sizes 1 and 2.
- R4: A data-port access (offsets 4 to 7, `up_off[2]`=1) with selector bit 31 set issues one request. Its `ecam_addr` is bus(bits 23:16)<<20 | device(bits 15:11)<<15 | function(bits 10:8)<<12 | (selector bits 7:2)<<2 | `up_off[1:0]`.
- R5: With selector bit 31 clear, data-port reads return 0 and data-port writes issue no downstream request.
- R6: Offsets 1, 2 and 3 read as 0. Writes there change nothing and issue no request.
- R7: `up_done` pulses for exactly one cycle per access. A local access completes one cycle after acceptance. A forwarded access completes one cycle after the `ecam_valid`/`ecam_ready` handshake. `ecam_valid` and its fields stay stable until `ecam_ready` is seen.
- R8: Forwarded reads return `ecam_rdata` masked to the access size (1 byte: bits 7:0, 2 bytes: bits 15:0, 4 bytes: all). Forwarded writes present `up_wdata`, `up_size` and `ecam_we`=1 unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| up_req | input | 1 | Upstream access request, held until up_done |
| up_we | input | 1 | 1 = write, 0 = read |
| up_off | input | 3 | Byte offset in the 8-byte window |
| up_size | input | 3 | Access size in bytes: 1, 2 or 4 |
| up_wdata | input | 32 | Upstream write data |
| up_rdata | output | 32 | Read result, valid while up_done is high |
| up_done | output | 1 | One-cycle completion strobe |
| ecam_valid | output | 1 | Downstream request valid |
| ecam_ready | input | 1 | Downstream request accepted and finished |
| ecam_we | output | 1 | Downstream write flag |
| ecam_addr | output | 28 | Computed configuration address |
| ecam_size | output | 3 | Downstream access size in bytes |
| ecam_wdata | output | 32 | Downstream write data |
| ecam_rdata | input | 32 | Downstream read data, valid with ecam_ready |

## Verification
The selector word is set to several bus/device/function/register mixes, including register offsets whose two low bits are set. This separates a correct field shift from an off-by-one placement, and shows whether the dword alignment drops the low bits. Data-port offsets 4, 6 and 7 are combined with sizes 1, 2 and 4, which tells the byte-lane OR apart from a fixed lane and shows that the size mask is applied. Selector writes of each size, accesses at the unused offsets, and data accesses with the enable flag clear are each checked against the read-back word and the downstream request count. A downstream model with a changing ready delay shows that completion follows the handshake and is not tied to a fixed latency.

// File: rtl/cfgb_pkg.sv
package cfgb_pkg;
  localparam int DW      = 32;
  localparam int OFF_W   = 3;
  localparam int SZ_W    = 3;
  localparam int BUS_W   = 8;
  localparam int DEV_W   = 5;
  localparam int FN_W    = 3;
  localparam int REG_W   = 12;
  localparam int EAW     = BUS_W + DEV_W + FN_W + REG_W;
  localparam int EN_BIT  = 31;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_RESP  = 2'd2
  } seq_st_t;

  function automatic logic [DW-1:0] size_mask(input logic [SZ_W-1:0] sz);
    logic [DW-1:0] m;
    case (sz)
      3'd1:    m = {{(DW-8){1'b0}}, 8'hFF};
      3'd2:    m = {{(DW-16){1'b0}}, 16'hFFFF};
      default: m = '1;
    endcase
    return m;
  endfunction
endpackage

// File: rtl/cfgb_addr_reg.sv
module cfgb_addr_reg
  import cfgb_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] q
);
  logic [DW-1:0] q_d;

  always_comb begin
    q_d = q;
    if (load) q_d = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= q_d;
  end
endmodule

// File: rtl/cfgb_decode.sv
module cfgb_decode
  import cfgb_pkg::*;
(
  input  logic [OFF_W-1:0] off,
  input  logic [SZ_W-1:0]  size,
  input  logic [DW-1:0]    sel_word,
  output logic             hit_sel,
  output logic             full_word,
  output logic             fwd,
  output logic [DW-1:0]    local_rdata,
  output logic [EAW-1:0]   ecam_addr
);
  localparam int BDF_W = BUS_W + DEV_W + FN_W;
  localparam int GAP_W = REG_W - 8;

  logic hit_data;

  always_comb begin
    hit_sel     = (off == '0);
    hit_data    = off[OFF_W-1];
    full_word   = (size == 3'd4);
    fwd         = hit_data && sel_word[EN_BIT];
    local_rdata = (hit_sel && full_word) ? sel_word : '0;
    ecam_addr   = {sel_word[8 +: BDF_W], {GAP_W{1'b0}}, sel_word[7:2], off[1:0]};
  end
endmodule

// File: rtl/cfgb_seq.sv
module cfgb_seq
  import cfgb_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            up_req,
  input  logic [SZ_W-1:0] up_size,
  input  logic            fwd,
  input  logic [DW-1:0]   local_rdata,
  input  logic            ecam_ready,
  input  logic [DW-1:0]   ecam_rdata,
  output logic            accept,
  output logic            ecam_valid,
  output logic            up_done,
  output logic [DW-1:0]   up_rdata
);
  seq_st_t       st_q, st_d;
  logic [DW-1:0] rd_q, rd_d;

  always_comb begin
    st_d   = st_q;
    rd_d   = rd_q;
    accept = 1'b0;
    case (st_q)
      ST_IDLE: begin
        if (up_req) begin
          accept = 1'b1;
          if (fwd) begin
            st_d = ST_ISSUE;
          end else begin
            st_d = ST_RESP;
            rd_d = local_rdata;
          end
        end
      end
      ST_ISSUE: begin
        if (ecam_ready) begin
          st_d = ST_RESP;
          rd_d = ecam_rdata & size_mask(up_size);
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_IDLE;
      rd_q <= '0;
    end else begin
      st_q <= st_d;
      rd_q <= rd_d;
    end
  end

  assign ecam_valid = (st_q == ST_ISSUE);
  assign up_done    = (st_q == ST_RESP);
  assign up_rdata   = rd_q;

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    up_done |=> !up_done);

  // R7
  hold_until_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ecam_valid && !ecam_ready) |=> ecam_valid);

  // R7
  done_after_hs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ecam_valid && ecam_ready) |=> (up_done && !ecam_valid));

  // R8
  byte_ext_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (up_done && up_size == 3'd1) |-> (up_rdata[DW-1:8] == '0));
endmodule

// File: rtl/cfg_port_bridge.sv
module cfg_port_bridge
  import cfgb_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             up_req,
  input  logic             up_we,
  input  logic [OFF_W-1:0] up_off,
  input  logic [SZ_W-1:0]  up_size,
  input  logic [DW-1:0]    up_wdata,
  output logic [DW-1:0]    up_rdata,
  output logic             up_done,
  output logic             ecam_valid,
  input  logic             ecam_ready,
  output logic             ecam_we,
  output logic [EAW-1:0]   ecam_addr,
  output logic [SZ_W-1:0]  ecam_size,
  output logic [DW-1:0]    ecam_wdata,
  input  logic [DW-1:0]    ecam_rdata
);
  logic [1:0]    rst_sync_q;
  logic          rst_int_n;
  logic [DW-1:0] sel_word;
  logic          hit_sel, full_word, fwd, accept, sel_load;
  logic [DW-1:0] local_rdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  assign sel_load = accept && up_we && hit_sel && full_word;

  cfgb_addr_reg u_sel (
    .clk   (clk),
    .rst_n (rst_int_n),
    .load  (sel_load),
    .wdata (up_wdata),
    .q     (sel_word)
  );

  cfgb_decode u_dec (
    .off         (up_off),
    .size        (up_size),
    .sel_word    (sel_word),
    .hit_sel     (hit_sel),
    .full_word   (full_word),
    .fwd         (fwd),
    .local_rdata (local_rdata),
    .ecam_addr   (ecam_addr)
  );

  cfgb_seq u_seq (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .up_req      (up_req),
    .up_size     (up_size),
    .fwd         (fwd),
    .local_rdata (local_rdata),
    .ecam_ready  (ecam_ready),
    .ecam_rdata  (ecam_rdata),
    .accept      (accept),
    .ecam_valid  (ecam_valid),
    .up_done     (up_done),
    .up_rdata    (up_rdata)
  );

  assign ecam_we    = up_we;
  assign ecam_size  = up_size;
  assign ecam_wdata = up_wdata;

  // R2
  sel_hold_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    !(up_req && up_we && up_off == '0 && up_size == 3'd4) |=> $stable(sel_word));

  // R5
  no_req_disabled_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    ecam_valid |-> sel_word[EN_BIT]);

  // R4
  lane_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    ecam_valid |-> (ecam_addr[1:0] == up_off[1:0] && up_off[2]));

  // R7
  addr_stable_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (ecam_valid && !ecam_ready) |=> $stable(ecam_addr));
endmodule

// File: tb/cfg_port_bridge_tb_top.sv
`timescale 1ns/1ps
module cfg_port_bridge_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        up_req = 1'b0, up_we = 1'b0;
  logic [2:0]  up_off = '0, up_size = 3'd4;
  logic [31:0] up_wdata = '0;
  logic [31:0] up_rdata;
  logic        up_done;
  logic        ecam_valid, ecam_we;
  logic        ecam_ready = 1'b0;
  logic [27:0] ecam_addr;
  logic [2:0]  ecam_size;
  logic [31:0] ecam_wdata, ecam_rdata;

  int errors = 0, checks = 0;
  int delay = 1, hs_cnt = 0, wait_cnt = 0;
  logic [27:0] last_addr;
  logic [2:0]  last_size;
  logic        last_we;
  logic [31:0] last_wdata;

  always #2.5 clk = ~clk;

  cfg_port_bridge dut_i (
    .clk(clk), .rst_n(rst_n), .up_req(up_req), .up_we(up_we), .up_off(up_off),
    .up_size(up_size), .up_wdata(up_wdata), .up_rdata(up_rdata), .up_done(up_done),
    .ecam_valid(ecam_valid), .ecam_ready(ecam_ready), .ecam_we(ecam_we),
    .ecam_addr(ecam_addr), .ecam_size(ecam_size), .ecam_wdata(ecam_wdata),
    .ecam_rdata(ecam_rdata)
  );

  function automatic logic [31:0] model(input logic [27:0] a);
    return {a[7:0], a[15:8], 8'hC3, a[7:0]} ^ 32'h5A00_0000;
  endfunction
  assign ecam_rdata = model(ecam_addr);

  function automatic logic [27:0] exp_addr(input logic [31:0] s, input logic [2:0] off);
    return (28'(s[23:16]) << 20) | (28'(s[15:11]) << 15) | (28'(s[10:8]) << 12)
         | 28'(s[7:0] & 8'hFC) | 28'(off[1:0]);
  endfunction

  function automatic logic [31:0] mask(input logic [2:0] sz);
    return (sz == 3'd1) ? 32'hFF : (sz == 3'd2) ? 32'hFFFF : 32'hFFFF_FFFF;
  endfunction

  // downstream responder, driven away from the active edge
  always @(negedge clk) begin
    if (ecam_valid) begin
      wait_cnt = wait_cnt + 1;
      ecam_ready = (wait_cnt >= delay);
      if (ecam_ready) begin
        hs_cnt++;
        last_addr = ecam_addr; last_size = ecam_size;
        last_we = ecam_we; last_wdata = ecam_wdata;
      end
    end else begin
      wait_cnt = 0;
      ecam_ready = 1'b0;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic access(input logic we, input logic [2:0] off, input logic [2:0] sz,
                        input logic [31:0] wd, output logic [31:0] rd, output int lat);
    up_we = we; up_off = off; up_size = sz; up_wdata = wd; up_req = 1'b1;
    lat = 0;
    do begin
      @(negedge clk);
      lat++;
    end while (!up_done && lat < 100);
    if (!up_done) begin
      errors++;
      $display("FAIL R7: access hung actual=%0d expected=done", lat);
    end
    rd = up_rdata;
    up_req = 1'b0;
    @(negedge clk);
  endtask

  logic [31:0] rd;
  int lat;

  task automatic t_reset();
    int h0;
    access(1'b0, 3'd0, 3'd4, '0, rd, lat);
    check("R1 selector reset", rd, 32'h0);
    h0 = hs_cnt;
    access(1'b0, 3'd4, 3'd4, '0, rd, lat);
    check("R1 data read after reset", rd, 32'h0);
    check("R1 no request after reset", hs_cnt, h0);
  endtask

  task automatic t_selector();
    access(1'b1, 3'd0, 3'd4, 32'h8012_3A44, rd, lat);
    access(1'b0, 3'd0, 3'd4, '0, rd, lat);
    check("R2/R3 full write readback", rd, 32'h8012_3A44);
    access(1'b1, 3'd0, 3'd2, 32'h0000_FFFF, rd, lat);
    access(1'b1, 3'd0, 3'd1, 32'h0000_00FF, rd, lat);
    access(1'b0, 3'd0, 3'd4, '0, rd, lat);
    check("R2 narrow writes ignored", rd, 32'h8012_3A44);
    access(1'b0, 3'd0, 3'd1, '0, rd, lat);
    check("R3 byte read zero", rd, 32'h0);
    access(1'b0, 3'd0, 3'd2, '0, rd, lat);
    check("R3 half read zero", rd, 32'h0);
  endtask

  task automatic t_translate(input logic [31:0] s, input logic [2:0] off, input logic [2:0] sz);
    int h0;
    access(1'b1, 3'd0, 3'd4, s, rd, lat);
    h0 = hs_cnt;
    access(1'b0, off, sz, '0, rd, lat);
    check("R4 one request", hs_cnt, h0 + 1);
    check("R4 ecam address", 32'(last_addr), 32'(exp_addr(s, off)));
    check("R8 read size passed", 32'(last_size), 32'(sz));
    check("R8 read zero-extended", rd, model(exp_addr(s, off)) & mask(sz));
  endtask

  task automatic t_write_pass();
    access(1'b1, 3'd0, 3'd4, 32'h8003_1F10, rd, lat);
    access(1'b1, 3'd6, 3'd2, 32'h1234_BEEF, rd, lat);
    check("R8 write flag", 32'(last_we), 32'h1);
    check("R8 write data", last_wdata, 32'h1234_BEEF);
    check("R8 write size", 32'(last_size), 32'd2);
    check("R4 write address", 32'(last_addr), 32'(exp_addr(32'h8003_1F10, 3'd6)));
  endtask

  task automatic t_disabled();
    int h0;
    access(1'b1, 3'd0, 3'd4, 32'h00AB_CDEF, rd, lat);
    h0 = hs_cnt;
    access(1'b1, 3'd5, 3'd4, 32'hFFFF_FFFF, rd, lat);
    access(1'b0, 3'd4, 3'd4, '0, rd, lat);
    check("R5 disabled read zero", rd, 32'h0);
    check("R5 no request when disabled", hs_cnt, h0);
  endtask

  task automatic t_outside();
    int h0;
    access(1'b1, 3'd0, 3'd4, 32'h8055_5504, rd, lat);
    h0 = hs_cnt;
    for (int o = 1; o < 4; o++) begin
      access(1'b1, 3'(o), 3'd4, 32'h1111_2222, rd, lat);
      access(1'b0, 3'(o), 3'd4, '0, rd, lat);
      check("R6 unused offset reads zero", rd, 32'h0);
    end
    access(1'b0, 3'd0, 3'd4, '0, rd, lat);
    check("R6 selector untouched", rd, 32'h8055_5504);
    check("R6 no request", hs_cnt, h0);
  endtask

  task automatic t_stall();
    access(1'b0, 3'd0, 3'd4, '0, rd, lat);
    check("R7 local latency", lat, 1);
    access(1'b1, 3'd0, 3'd4, 32'h8001_0803, rd, lat);
    for (int d = 1; d <= 6; d += 5) begin
      delay = d;
      access(1'b0, 3'd7, 3'd1, '0, rd, lat);
      check("R7 forwarded latency", lat, d + 1);
    end
    delay = 1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_selector();
    t_translate(32'h80AB_5E7C, 3'd4, 3'd4);
    t_translate(32'h80AB_5E7C, 3'd6, 3'd2);
    t_translate(32'h80AB_5E7C, 3'd7, 3'd1);
    t_translate(32'h8001_0803, 3'd5, 3'd1);
    t_write_pass();
    t_disabled();
    t_outside();
    t_stall();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL R7: watchdog actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule